// File: doc/BRIEF.md
# Triangle Down-Spread Divide Modulator

This block sits beside the feedback divider of a clock synthesizer and makes the loop's divide ratio follow a slow triangle wave. It runs on the reference clock. It takes the nominal integer feedback value and a spread enable bit. It produces a registered, unsigned fixed-point divide value for a fractional-N stage that lies outside this block. While the spread is off, the output is exactly the nominal value with a zero fraction. While the spread is on, the output never rises above the nominal value. It sweeps linearly down to a fixed depth below nominal and climbs back, so the synthesized frequency only dips below its programmed value.

A free-running phase counter sets the shape of the triangle. One full sweep lasts 512 reference cycles, which gives a modulation rate of the reference divided by 512. Each ramp, rising or falling, lasts 256 cycles. The depth is set as a parameter in parts per million, 5000 ppm by default, and is turned into a fixed-point code when the block is elaborated. A parameter selects whether the scaled dip is truncated or rounded.

Top module: `ssc_triangle_gen`

## Requirements
- R1: While reset is high, the output equals the nominal value times 2^16 and the phase is cleared. The first enabled edge after reset therefore produces the bottom of the sweep.
- R2: When the enable is low at a clock edge, the output after that edge equals the nominal value sampled at that edge, shifted left by 16.
- R3: The output is 25 bits wide. Bits 24..16 hold the integer part and bits 15..0 hold the fraction. The fraction is zero whenever the spread is off.
- R4: With spread on, the output after an edge is M·2^16 − floor(M·D·(256 − r)/256). Here M is the nominal value sampled at that edge, D = floor(5000·2^16/10^6) = 327, and r is the ramp position for the current phase.
- R5: Phases 0 to 255 form the rising half, where r equals the phase. The first enabled edge uses phase 0, which gives the bottom value M·2^16 − M·327.
- R6: At phase 256, r is 256 and the output equals M·2^16. Phases 257 to 511 give r = 512 − phase. The phase then wraps to 0, so the sweep repeats every 512 enabled cycles.
- R7: With spread on, the output never exceeds M·2^16. It never falls below M·2^16 − floor(M·0.006·2^16).
- R8: Dropping the enable returns the output to M·2^16 at the next edge and clears the phase.
- R9: Raising the enable again restarts the sweep at the bottom, at phase 0.
- R10: A change of the nominal value while the spread is on takes effect at the next edge and does not disturb the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ssc_en | input | 1 | Spread enable, 1 = sweep on |
| m_nom | input | 9 | Nominal integer feedback value |
| div_q | output | 25 | Registered divide value, 9 integer and 16 fraction bits |

## Verification
The bench builds the block with its default parameters: a 9-bit nominal value, 16 fraction bits, 256-cycle ramps, a 5000 ppm depth and truncation. These values make a full 512-cycle sweep and its wrap short enough to follow edge by edge for several nominal values. They also allow the widest nominal value of 511, where the product of value, depth code and ramp distance is largest. Disable and re-enable in mid-sweep, and a change of the nominal value at a known phase, can all be compared against the closed-form expression.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam longint unsigned PPM_SCALE = 1000000;

  // fixed-point code for a fraction given in parts per million
  function automatic longint unsigned ppm_to_code(input longint unsigned ppm,
                                                  input int unsigned frac_bits);
    return (ppm << frac_bits) / PPM_SCALE;
  endfunction

  typedef enum logic {
    SWEEP_RISE = 1'b0,
    SWEEP_FALL = 1'b1
  } sweep_dir_e;

endpackage

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr #(
  parameter int HALF_LOG2 = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  output logic [HALF_LOG2:0]   ramp
);
  import ssc_pkg::*;

  localparam int PH_W = HALF_LOG2 + 1;
  localparam logic [HALF_LOG2:0] HALF = PH_W'(1) << HALF_LOG2;

  logic [PH_W-1:0] phase;
  sweep_dir_e      dir;
  logic [HALF_LOG2:0] pos;

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  assign dir = phase[HALF_LOG2] ? SWEEP_FALL : SWEEP_RISE;
  assign pos = {1'b0, phase[HALF_LOG2-1:0]};

  always_comb begin
    if (dir == SWEEP_FALL) ramp = HALF - pos;
    else                   ramp = pos;
  end

  // R6
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && phase == '1) |=> (phase == '0));

  // R5
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> (((ramp > $past(ramp)) ? (ramp - $past(ramp))
                                             : ($past(ramp) - ramp)) == PH_W'(1)));

  // R8
  phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0));

endmodule

// File: rtl/ssc_depth_scale.sv
module ssc_depth_scale #(
  parameter int          M_W           = 9,
  parameter int          FRAC_W        = 16,
  parameter int          HALF_LOG2     = 8,
  parameter int unsigned DEPTH_CODE    = 327,
  parameter bit          ROUND_NEAREST = 1'b0
) (
  input  logic [M_W-1:0]        m_val,
  input  logic [HALF_LOG2:0]    ramp,
  output logic [M_W+FRAC_W-1:0] value
);
  localparam int OUT_W = M_W + FRAC_W;
  localparam int PW    = M_W + FRAC_W + HALF_LOG2 + 1;
  localparam logic [HALF_LOG2:0] HALF = (HALF_LOG2+1)'(1) << HALF_LOG2;

  logic [HALF_LOG2:0] gap;
  logic [PW-1:0]      prod;
  logic [PW-1:0]      dip;
  logic [OUT_W-1:0]   nominal;

  assign gap     = HALF - ramp;
  assign prod    = PW'(m_val) * PW'(DEPTH_CODE) * PW'(gap);
  assign nominal = {m_val, {FRAC_W{1'b0}}};

  generate
    if (ROUND_NEAREST) begin : g_round
      assign dip = (prod + (PW'(1) << (HALF_LOG2 - 1))) >> HALF_LOG2;
    end else begin : g_trunc
      assign dip = prod >> HALF_LOG2;
    end
  endgenerate

  assign value = nominal - dip[OUT_W-1:0];

  // R7
  scale_ceiling_chk: assert final (value <= nominal);

endmodule

// File: rtl/ssc_triangle_gen.sv
module ssc_triangle_gen #(
  parameter int          M_W           = 9,
  parameter int          FRAC_W        = 16,
  parameter int          HALF_LOG2     = 8,
  parameter int unsigned SPREAD_PPM    = 5000,
  parameter int unsigned LIMIT_PPM     = 6000,
  parameter bit          ROUND_NEAREST = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ssc_en,
  input  logic [M_W-1:0]          m_nom,
  output logic [M_W+FRAC_W-1:0]   div_q
);
  import ssc_pkg::*;

  localparam int          OUT_W = M_W + FRAC_W;
  localparam int          LW    = OUT_W + FRAC_W + 1;
  localparam int unsigned DCODE = int'(ppm_to_code(SPREAD_PPM, FRAC_W));
  localparam int unsigned LCODE = int'(ppm_to_code(LIMIT_PPM, FRAC_W));

  logic [HALF_LOG2:0] ramp;
  logic [OUT_W-1:0]   swept;

  ssc_phase_ctr #(.HALF_LOG2(HALF_LOG2)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .run  (ssc_en),
    .ramp (ramp)
  );

  ssc_depth_scale #(
    .M_W           (M_W),
    .FRAC_W        (FRAC_W),
    .HALF_LOG2     (HALF_LOG2),
    .DEPTH_CODE    (DCODE),
    .ROUND_NEAREST (ROUND_NEAREST)
  ) u_scale (
    .m_val (m_nom),
    .ramp  (ramp),
    .value (swept)
  );

  always_ff @(posedge clk) begin
    if (rst || !ssc_en) div_q <= {m_nom, {FRAC_W{1'b0}}};
    else                div_q <= swept;
  end

  // R7
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    ssc_en |=> (div_q <= {$past(m_nom), {FRAC_W{1'b0}}}));

  // R7
  depth_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ssc_en |=> ((LW'(div_q) + LW'($past(m_nom)) * LW'(LCODE))
                >= (LW'($past(m_nom)) << FRAC_W)));

  // R8
  off_nominal_chk: assert property (@(posedge clk) disable iff (rst)
    !ssc_en |=> (div_q == {$past(m_nom), {FRAC_W{1'b0}}}));

  // R9
  start_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ssc_en) |=> ((LW'(div_q) + LW'($past(m_nom)) * LW'(DCODE))
                       == (LW'($past(m_nom)) << FRAC_W)));

endmodule

// File: tb/tb_ssc_triangle_gen.sv
module tb_ssc_triangle_gen;

  localparam longint D    = (64'd5000 * 64'd65536) / 64'd1000000;
  localparam longint LIM6 = 64'd6000;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [8:0]  m;
  logic [24:0] q;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ssc_triangle_gen dut (
    .clk    (clk),
    .rst    (rst),
    .ssc_en (en),
    .m_nom  (m),
    .div_q  (q)
  );

  function automatic longint expv(input longint mm, input int k);
    int ph;
    int r;
    ph = k % 512;
    r  = (ph < 256) ? ph : 512 - ph;
    return (mm <<< 16) - ((mm * D * longint'(256 - r)) >>> 8);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bounds(input longint mm);
    longint lo;
    lo = (mm <<< 16) - ((mm * LIM6 * 65536) / 1000000);
    chk("R7 bounds", (longint'(q) <= (mm <<< 16) && longint'(q) >= lo) ? 1 : 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1; m = 9'd192;
    repeat (2) @(negedge clk);
    chk("R1 reset value", q, 64'd192 <<< 16);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 phase cleared", q, expv(192, 0));
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    int vals[3] = '{120, 240, 0};
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      m = 9'(vals[i]);
      @(negedge clk);
      chk("R2 off value", q, longint'(vals[i]) <<< 16);
      chk("R3 fraction zero", q[15:0], 0);
    end
  endtask

  task automatic t_sweep(input int mv, input int cycles);
    m = 9'(mv); en = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (k == 0)                chk("R5 bottom", q, expv(mv, k));
      else if (k % 512 == 256)   chk("R6 peak", q, longint'(mv) <<< 16);
      else if (k == 512)         chk("R6 wrap", q, expv(mv, 0));
      else                       chk("R4 sweep", q, expv(mv, k));
      if (k % 64 == 0) bounds(mv);
    end
    en = 1'b0;
    @(negedge clk);
    chk("R8 off at once", q, longint'(mv) <<< 16);
  endtask

  task automatic t_reenable();
    m = 9'd200; en = 1'b1;
    for (int k = 0; k < 77; k++) begin
      @(negedge clk);
      chk("R4 pre-stop", q, expv(200, k));
    end
    en = 1'b0;
    @(negedge clk);
    chk("R8 stop", q, 64'd200 <<< 16);
    en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 restart", q, expv(200, k));
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_m_change();
    m = 9'd160; en = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      chk("R4 before change", q, expv(160, k));
    end
    m = 9'd230;
    for (int k = 300; k < 320; k++) begin
      @(negedge clk);
      chk("R10 new M", q, expv(230, k));
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; en = 1'b0; m = '0;
    t_reset();
    t_disabled();
    t_sweep(192, 1100);
    t_sweep(511, 600);
    t_sweep(120, 520);
    t_reenable();
    t_m_change();
    summary();
  end

endmodule